// File: doc/BRIEF.md
# Split Fast/Normal Interrupt Controller

This block collects two groups of interrupt sources and hands them on as per-source request vectors plus one summary line per group. The fast group (32 sources by default) is edge sensitive: each source is brought into the clock domain through a synchroniser, a selected edge is latched as pending, and software acknowledges it by writing one to a clear register. The normal group (64 sources by default) is level sensitive: the request follows the synchronised input, corrected for its polarity, with no latching.

Software programs the block through a plain register port. Every control register holds 16 source bits. A source's register index is its number divided by 16 and its bit is the remainder. Consecutive registers of one kind sit 4 address units apart. Each group has its own mask and polarity registers, and the fast group also has a clear register. A set mask bit blocks a source. Reads are combinational.

Top module: `split_intc`

## Requirements
- R1: After reset every source is masked (mask registers read 0xFFFF), every polarity bit reads 0, nothing is pending, and all request vectors and summary lines are 0.
- R2: Register map with the default parameters: fast mask at 0x00/0x04, fast polarity at 0x08/0x0C, fast clear at 0x10/0x14, normal mask at 0x20/0x24/0x28/0x2C, normal polarity at 0x30/0x34/0x38/0x3C. Source n of a group sits in that group's register n/16, at bit n%16. Mask and polarity registers read back what was written. Clear registers and unmapped addresses read 0.
- R3: With its polarity bit 0, a fast source latches on a rising edge. It stays pending after the input returns low.
- R4: With its polarity bit 1, a fast source latches on a falling edge only, and a rising edge leaves it untouched.
- R5: A fast edge is latched even while the source is masked. The request appears once the mask bit is cleared, and a set mask bit forces the request to 0.
- R6: Writing 1 to a fast clear bit removes that source's pending state. Writing 0 leaves it pending.
- R7: If a new selected edge and a clear write to the same bit happen in the same cycle, the source stays pending.
- R8: A normal source requests while its input is high when its polarity bit is 0, and while its input is low when its polarity bit is 1. A polarity write takes effect on the next cycle.
- R9: A set normal mask bit forces that source's request to 0, and clearing the mask bit lets it through again.
- R10: Each summary line is the OR of its group's masked request vector.
- R11: A fast input change shows on its request output after the third rising clock edge. A normal input change shows after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for reads and writes |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Combinational read data at `addr` |
| fast_src | input | 32 | Raw fast (edge) sources, asynchronous |
| norm_src | input | 64 | Raw normal (level) sources, asynchronous |
| fast_req | output | 32 | Pending and unmasked fast sources |
| fast_any | output | 1 | OR of `fast_req` |
| norm_req | output | 64 | Polarity-corrected, unmasked normal sources |
| norm_any | output | 1 | OR of `norm_req` |

## Verification
The bench builds the block with its defaults: 32 fast sources, 64 normal sources, 16-bit registers and a two-stage synchroniser. These values make the last register of each group reachable, so sources 31 and 63 test the top of the index arithmetic, and a source in normal register 2 tests a middle register of the four. The two-stage synchroniser fixes the latencies of three and two edges. The bench can time a clear write onto the exact edge-detect cycle only because these latencies are known.

// File: rtl/split_intc_pkg.sv
package split_intc_pkg;
   // Address distance between consecutive registers of one kind.
   localparam int REG_STRIDE = 4;

   // Number of registers needed to hold n source bits.
   function automatic int regs_for(input int n, input int w);
      return n / w;
   endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("intc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/intc_reg_group.sv
module intc_reg_group
   import split_intc_pkg::*;
#(
   parameter int N       = 32,
   parameter int REG_W   = 16,
   parameter int ADDR_W  = 8,
   parameter int BASE    = 0,
   parameter bit RST_VAL = 1'b0,
   parameter bit PULSE   = 1'b0   // 1: write-one pulse group, no storage
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [N-1:0]      bits_o,
   output logic [REG_W-1:0]  rd_data
);
   localparam int NREG = regs_for(N, REG_W);

   if (N % REG_W != 0) begin : g_bad
      $error("intc_reg_group: N must be a multiple of REG_W");
   end

   logic [NREG-1:0] sel;
   for (genvar r = 0; r < NREG; r++) begin : g_sel
      assign sel[r] = (addr == ADDR_W'(BASE + r * REG_STRIDE));
   end

   if (PULSE) begin : g_pulse
      for (genvar r = 0; r < NREG; r++) begin : g_bits
         assign bits_o[r*REG_W +: REG_W] = (wr_en && sel[r]) ? wr_data : '0;
      end
      assign rd_data = '0;

      // R6: clear pulses exist only during a register write
      assert_pulse_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (|bits_o) |-> wr_en);
   end else begin : g_store
      logic [N-1:0] q;
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q[r*REG_W +: REG_W] <= {REG_W{RST_VAL}};
            else if (wr_en && sel[r])  q[r*REG_W +: REG_W] <= wr_data;
         end
      end
      always_comb begin
         rd_data = '0;
         for (int r = 0; r < NREG; r++)
            if (sel[r]) rd_data = q[r*REG_W +: REG_W];
      end
      assign bits_o = q;

      // R2: a write is read back on the following cycle
      assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && sel[0]) |=> (q[REG_W-1:0] == $past(wr_data)));
   end
endmodule

// File: rtl/intc_edge_bank.sv
module intc_edge_bank #(
   parameter int N         = 32,
   parameter int REG_W     = 16,
   parameter int ADDR_W    = 8,
   parameter int STAGES    = 2,
   parameter int MASK_BASE = 'h00,
   parameter int POL_BASE  = 'h08,
   parameter int CLR_BASE  = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [N-1:0]      src,
   output logic [N-1:0]      req,
   output logic              any,
   output logic [REG_W-1:0]  rd_data
);
   logic [N-1:0] s, prev_q, pend_q, mask, pol, clr, edge_v;
   logic [REG_W-1:0] rd_m, rd_p, rd_c;

   intc_sync #(.W(N), .STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src), .q(s));

   intc_reg_group #(.N(N), .REG_W(REG_W), .ADDR_W(ADDR_W), .BASE(MASK_BASE),
                    .RST_VAL(1'b1), .PULSE(1'b0)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .bits_o(mask), .rd_data(rd_m));

   intc_reg_group #(.N(N), .REG_W(REG_W), .ADDR_W(ADDR_W), .BASE(POL_BASE),
                    .RST_VAL(1'b0), .PULSE(1'b0)) u_pol (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .bits_o(pol), .rd_data(rd_p));

   intc_reg_group #(.N(N), .REG_W(REG_W), .ADDR_W(ADDR_W), .BASE(CLR_BASE),
                    .RST_VAL(1'b0), .PULSE(1'b1)) u_clr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .bits_o(clr), .rd_data(rd_c));

   assign rd_data = rd_m | rd_p | rd_c;

   // Polarity 0 picks rising, 1 picks falling; one direction per source.
   assign edge_v = (~pol & ~prev_q & s) | (pol & prev_q & ~s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= s;
         pend_q <= edge_v | (pend_q & ~clr);   // new edge beats clear
      end
   end

   assign req = pend_q & ~mask;
   assign any = |req;

   logic mask0_wr, clr0_wr;
   assign mask0_wr = wr_en && (addr == ADDR_W'(MASK_BASE));
   assign clr0_wr  = wr_en && (addr == ADDR_W'(CLR_BASE));

   // R5: bits masked by a write give no request afterwards
   assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mask0_wr |=> ((req[REG_W-1:0] & $past(wr_data)) == '0));
   // R6: cleared bits with no fresh edge are gone next cycle
   assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr0_wr |=> ((pend_q[REG_W-1:0] & $past(wr_data) & ~$past(edge_v[REG_W-1:0])) == '0));
   // R7: an edge coinciding with a clear still leaves the bit pending
   assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(edge_v & clr)) |=> (($past(edge_v & clr) & ~pend_q) == '0));
   // R3: pending survives while no clear targets it
   assert_pending_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_q & ~clr)) |=> (($past(pend_q & ~clr) & ~pend_q) == '0));
   // R4: a rising edge on a falling-selected idle source latches nothing
   assert_rise_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pol & ~prev_q & s & ~pend_q)) |=> (($past(pol & ~prev_q & s & ~pend_q) & pend_q) == '0));
endmodule

// File: rtl/intc_level_bank.sv
module intc_level_bank #(
   parameter int N         = 64,
   parameter int REG_W     = 16,
   parameter int ADDR_W    = 8,
   parameter int STAGES    = 2,
   parameter int MASK_BASE = 'h20,
   parameter int POL_BASE  = 'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [N-1:0]      src,
   output logic [N-1:0]      req,
   output logic              any,
   output logic [REG_W-1:0]  rd_data
);
   logic [N-1:0] s, mask, pol;
   logic [REG_W-1:0] rd_m, rd_p;

   intc_sync #(.W(N), .STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src), .q(s));

   intc_reg_group #(.N(N), .REG_W(REG_W), .ADDR_W(ADDR_W), .BASE(MASK_BASE),
                    .RST_VAL(1'b1), .PULSE(1'b0)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .bits_o(mask), .rd_data(rd_m));

   intc_reg_group #(.N(N), .REG_W(REG_W), .ADDR_W(ADDR_W), .BASE(POL_BASE),
                    .RST_VAL(1'b0), .PULSE(1'b0)) u_pol (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .bits_o(pol), .rd_data(rd_p));

   assign rd_data = rd_m | rd_p;

   // Polarity 1 turns the source active-low.
   assign req = (s ^ pol) & ~mask;
   assign any = |req;

   logic mask0_wr;
   assign mask0_wr = wr_en && (addr == ADDR_W'(MASK_BASE));

   // R9: bits masked by a write give no request afterwards
   assert_level_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mask0_wr |=> ((req[REG_W-1:0] & $past(wr_data)) == '0));
   // R1: leaving reset, the group is fully masked
   assert_reset_masked_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (req == '0));
endmodule

// File: rtl/split_intc.sv
module split_intc #(
   parameter int FAST_N         = 32,
   parameter int NORM_N         = 64,
   parameter int REG_W          = 16,
   parameter int ADDR_W         = 8,
   parameter int SYNC_STAGES    = 2,
   parameter int FAST_MASK_BASE = 'h00,
   parameter int FAST_POL_BASE  = 'h08,
   parameter int FAST_CLR_BASE  = 'h10,
   parameter int NORM_MASK_BASE = 'h20,
   parameter int NORM_POL_BASE  = 'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic [FAST_N-1:0] fast_src,
   input  logic [NORM_N-1:0] norm_src,
   output logic [FAST_N-1:0] fast_req,
   output logic              fast_any,
   output logic [NORM_N-1:0] norm_req,
   output logic              norm_any
);
   localparam int FAST_SPAN = (FAST_N / REG_W) * split_intc_pkg::REG_STRIDE;
   localparam int NORM_SPAN = (NORM_N / REG_W) * split_intc_pkg::REG_STRIDE;

   if (FAST_MASK_BASE + FAST_SPAN > FAST_POL_BASE ||
       FAST_POL_BASE  + FAST_SPAN > FAST_CLR_BASE ||
       FAST_CLR_BASE  + FAST_SPAN > NORM_MASK_BASE ||
       NORM_MASK_BASE + NORM_SPAN > NORM_POL_BASE ||
       NORM_POL_BASE  + NORM_SPAN > (1 << ADDR_W)) begin : g_bad_map
      $error("split_intc: register groups overlap or exceed the address space");
   end

   logic [REG_W-1:0] rd_fast, rd_norm;

   intc_edge_bank #(.N(FAST_N), .REG_W(REG_W), .ADDR_W(ADDR_W), .STAGES(SYNC_STAGES),
                    .MASK_BASE(FAST_MASK_BASE), .POL_BASE(FAST_POL_BASE),
                    .CLR_BASE(FAST_CLR_BASE)) u_fast (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .src(fast_src), .req(fast_req), .any(fast_any), .rd_data(rd_fast));

   intc_level_bank #(.N(NORM_N), .REG_W(REG_W), .ADDR_W(ADDR_W), .STAGES(SYNC_STAGES),
                     .MASK_BASE(NORM_MASK_BASE), .POL_BASE(NORM_POL_BASE)) u_norm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .src(norm_src), .req(norm_req), .any(norm_any), .rd_data(rd_norm));

   assign rd_data = rd_fast | rd_norm;

   // R10: a summary line never rises with an empty vector
   assert_summary_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_any || norm_any) |-> ((fast_req != '0) || (norm_req != '0)));
endmodule

// File: tb/tb_split_intc.sv
`timescale 1ns/1ps
module tb_split_intc;
   localparam int K_FREQ = 0, K_FANY = 1, K_NREQ = 2, K_NANY = 3, K_RD = 4;

   typedef struct {
      int          kind;
      logic [63:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [31:0] fast_src = '0;
   logic [63:0] norm_src = '0;
   logic [31:0] fast_req;
   logic        fast_any;
   logic [63:0] norm_req;
   logic        norm_any;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   item_t sb[$];

   always #2 clk = ~clk;

   split_intc dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .fast_src(fast_src), .norm_src(norm_src),
      .fast_req(fast_req), .fast_any(fast_any), .norm_req(norm_req),
      .norm_any(norm_any));

   // Monitor: pops expected items and compares at the falling edge.
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [63:0] act;
         it = sb.pop_front();
         case (it.kind)
            K_FREQ:  act = {32'b0, fast_req};
            K_FANY:  act = {63'b0, fast_any};
            K_NREQ:  act = norm_req;
            K_NANY:  act = {63'b0, norm_any};
            default: act = {48'b0, rd_data};
         endcase
         n_checks++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_val(input int kind, input logic [63:0] exp, input string tag);
      sb.push_back('{kind, exp, tag});
      @(negedge clk);
      #1;
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic rd_check(input logic [7:0] a, input logic [15:0] exp, input string tag);
      addr = a;
      #0;
      expect_val(K_RD, {48'b0, exp}, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick(1);

      // R1 reset state
      expect_val(K_FREQ, 64'h0, "R1 fast_req after reset");
      expect_val(K_NREQ, 64'h0, "R1 norm_req after reset");
      expect_val(K_FANY, 64'h0, "R1 fast_any after reset");
      rd_check(8'h04, 16'hFFFF, "R1 fast mask reg1 reset");
      rd_check(8'h2C, 16'hFFFF, "R1 norm mask reg3 reset");
      rd_check(8'h38, 16'h0000, "R1 norm pol reg2 reset");
      rd_check(8'h14, 16'h0000, "R2 clear reg reads zero");

      // R2 unmask the whole fast group and read back
      reg_write(8'h00, 16'h0000);
      reg_write(8'h04, 16'h0000);
      rd_check(8'h04, 16'h0000, "R2 fast mask reg1 readback");
      rd_check(8'h44, 16'h0000, "R2 unmapped address reads zero");

      // R3/R11 rising edge on source 31
      fast_src[31] = 1'b1;
      tick(2);
      expect_val(K_FREQ, 64'h0, "R11 fast not visible before third edge");
      tick(1);
      expect_val(K_FREQ, 64'h8000_0000, "R11 R3 fast source 31 latched");
      expect_val(K_FANY, 64'h1, "R10 fast_any with pending source");
      fast_src[31] = 1'b0;
      tick(4);
      expect_val(K_FREQ, 64'h8000_0000, "R3 stays pending after input falls");

      // R6 clear, zero bits ignored
      reg_write(8'h14, 16'h8000);
      expect_val(K_FREQ, 64'h0, "R6 clear source 31");
      fast_src[0] = 1'b1;
      tick(3);
      reg_write(8'h10, 16'hFFFE);
      expect_val(K_FREQ, 64'h1, "R6 zero clear bit leaves source 0 pending");
      reg_write(8'h10, 16'h0001);
      expect_val(K_FREQ, 64'h0, "R6 clear source 0");

      // R4 falling selection on source 1
      reg_write(8'h08, 16'h0002);
      fast_src[1] = 1'b1;
      tick(4);
      expect_val(K_FREQ, 64'h0, "R4 rising edge ignored with polarity 1");
      fast_src[1] = 1'b0;
      tick(3);
      expect_val(K_FREQ, 64'h2, "R4 falling edge latched");
      reg_write(8'h10, 16'h0002);
      expect_val(K_FREQ, 64'h0, "R6 clear source 1");

      // R5 latched while masked
      reg_write(8'h00, 16'h0008);
      fast_src[3] = 1'b1;
      tick(1);
      fast_src[3] = 1'b0;
      tick(4);
      expect_val(K_FREQ, 64'h0, "R5 masked source gives no request");
      expect_val(K_FANY, 64'h0, "R10 fast_any low while only masked pending");
      reg_write(8'h00, 16'h0000);
      expect_val(K_FREQ, 64'h8, "R5 request appears on unmask");
      reg_write(8'h10, 16'h0008);

      // R7 edge in the same cycle as a clear
      fast_src[5] = 1'b1;
      tick(3);
      fast_src[5] = 1'b0;
      tick(3);
      fast_src[5] = 1'b1;
      tick(2);
      reg_write(8'h10, 16'h0020);
      expect_val(K_FREQ, 64'h20, "R7 new edge beats coinciding clear");
      reg_write(8'h10, 16'h0020);
      expect_val(K_FREQ, 64'h0, "R7 later clear removes source 5");

      // R8/R11 normal group, active high
      reg_write(8'h20, 16'h0000);
      reg_write(8'h2C, 16'h0000);
      expect_val(K_NREQ, 64'h0, "R8 idle normal inputs");
      norm_src[63] = 1'b1;
      tick(1);
      expect_val(K_NREQ, 64'h0, "R11 normal not visible before second edge");
      tick(1);
      expect_val(K_NREQ, 64'h8000_0000_0000_0000, "R11 R8 normal source 63 high");
      expect_val(K_NANY, 64'h1, "R10 norm_any with active source");
      norm_src[63] = 1'b0;
      tick(2);
      expect_val(K_NREQ, 64'h0, "R8 level request follows input low");

      // R8 active low
      reg_write(8'h30, 16'h0001);
      expect_val(K_NREQ, 64'h1, "R8 active-low source 0 requests while low");
      norm_src[0] = 1'b1;
      tick(2);
      expect_val(K_NREQ, 64'h0, "R8 active-low source 0 idle while high");

      // R9 normal mask on source 40 (register 2, bit 8)
      norm_src[40] = 1'b1;
      tick(3);
      expect_val(K_NREQ, 64'h0, "R9 masked normal source 40");
      expect_val(K_NANY, 64'h0, "R10 norm_any low when all masked");
      reg_write(8'h28, 16'hFEFF);
      expect_val(K_NREQ, 64'h0000_0100_0000_0000, "R9 R2 source 40 at reg2 bit 8");
      reg_write(8'h28, 16'hFFFF);
      expect_val(K_NREQ, 64'h0, "R9 re-mask source 40");

      // R2 readbacks
      rd_check(8'h30, 16'h0001, "R2 norm pol reg0 readback");
      rd_check(8'h28, 16'hFFFF, "R2 norm mask reg2 readback");
      rd_check(8'h08, 16'h0002, "R2 fast pol reg0 readback");
      rd_check(8'h0C, 16'h0000, "R2 fast pol reg1 untouched");

      tick(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule